// File: doc/BRIEF.md
# Interrupt Pending State Bank

This block holds the pending state for one bank of 32 consecutively numbered interrupts. The lowest interrupt number of the bank is a parameter. Each interrupt is set to edge or level triggering through a per-bit configuration input. The block keeps a pending latch that software writes can set and clear, and it keeps this latch apart from the live input line.

For edge-triggered interrupts, a rising transition on the line sets the latch. For level-triggered interrupts, the line only adds its current level to the value that reads see. Set-pending and clear-pending writes each carry a 32-bit mask. A per-interrupt activation strobe clears the latch the same way a clear-pending write does.

Two read values are produced. The first is the pending value a guest read would return. The second is the raw latch, which a save/restore agent can capture and later write back. A snapshot of the current line levels is also provided. Bits that fall in the software-generated range, or above the number of implemented interrupts, read as zero and ignore every write.

Top module: `pend_bank`

## Requirements
- R1: After a synchronous active-low reset, the latch output and the pending read value are all zero.
- R2: For an edge-triggered interrupt (trigger bit 1), a rising input line sets its latch at the next clock edge. The latch then stays set after the line falls.
- R3: An edge-triggered latch is cleared at the next clock edge by a clear-pending write with that mask bit set, or by an activation strobe on that bit. Otherwise it holds its value.
- R4: For a level-triggered interrupt (trigger bit 0), a high line makes the pending read bit 1 without setting the latch. When the line drops and the latch is clear, the pending read bit returns to 0.
- R5: For a level-triggered interrupt, a set-pending write sets the latch. The pending read bit then stays 1 after the line goes low.
- R6: For a level-triggered interrupt, a clear-pending write or an activation clears the latch. While the line is held high, the pending read bit stays 1.
- R7: When a set request and a clear request (a write or an activation) reach the same bit in the same cycle, the bit is set.
- R8: A restore write loads the latch from the restore data at the next clock edge, overriding set and clear requests in that cycle. The latch output always shows the raw latch. For an edge-triggered bit, the latch output is equal to the pending read bit.
- R9: Bit n of the level snapshot equals the current input line of interrupt base+n for every implemented bit.
- R10: A bit whose interrupt number is below the software-generated limit, or at or above the implemented count, reads 0 on all three outputs and ignores line, set, clear, activation and restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 32 | Interrupt input lines, bit n for interrupt base+n |
| trig_edge_i | input | 32 | Trigger type per bit: 1 edge, 0 level |
| set_we_i | input | 1 | Set-pending write strobe |
| set_mask_i | input | 32 | Bits to set pending |
| clr_we_i | input | 1 | Clear-pending write strobe |
| clr_mask_i | input | 32 | Bits to clear pending |
| activate_i | input | 32 | Per-interrupt activation strobe |
| restore_we_i | input | 1 | Latch restore strobe |
| restore_val_i | input | 32 | Latch value to restore |
| pend_rd_o | output | 32 | Guest-visible pending value |
| latch_o | output | 32 | Raw pending latch |
| level_snap_o | output | 32 | Current line level bitmap |

## Verification
Most faults show up on the latch output one clock after the request that caused them. Examples are a wrong latch bit, a dropped edge, or a clear that beats a set when it should lose. The pending read output is combinational, so a wrong OR with the line level for level-triggered bits is visible in the same cycle the line changes. Invalid-range bits should stay zero on every output whatever the stimulus, so a bad range mask is exposed by the first stimulus that touches them.

// File: rtl/pend_pkg.sv
// Package: shared constants and the implemented-bit mask function for the
// pending bank. Assumes a bank width of 32 interrupts.
package pend_pkg;
    localparam int BANK_W = 32;

    // Returns a mask with a 1 for each bank bit that maps to a real interrupt.
    function automatic logic [BANK_W-1:0] impl_mask(input int base_id,
                                                    input int num_impl,
                                                    input int sgi_limit);
        logic [BANK_W-1:0] m;
        for (int n = 0; n < BANK_W; n++) begin
            m[n] = ((base_id + n) >= sgi_limit) && ((base_id + n) < num_impl);
        end
        return m;
    endfunction
endpackage

// File: rtl/pend_edge_det.sv
// Module: registers the input lines and flags rising transitions.
// Assumes the lines are already synchronous to clk.
module pend_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] line_q_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] line_q;

    // Hold the previous-cycle line value.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_i;
    end

    // A rising transition is high now and low one cycle earlier.
    always_comb rise_o = line_i & ~line_q;

    assign line_q_o = line_q;
endmodule

// File: rtl/pend_cell.sv
// Module: pending latch for one implemented interrupt. Restore has the
// highest priority, then set, then clear. The visible pending value ORs
// in the live line when the bit is level triggered.
module pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic line,
    input  logic line_prev,
    input  logic rise,
    input  logic set_req,
    input  logic clr_req,
    input  logic restore_we,
    input  logic restore_bit,
    output logic latch_o,
    output logic pend_o
);
    logic latch_q;
    logic set_any;

    // Combine a software set with a detected edge on an edge-type bit.
    always_comb set_any = set_req | (edge_mode & rise);

    // Update the latch from restore, set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= 1'b0;
        else if (restore_we) latch_q <= restore_bit;
        else if (set_any)    latch_q <= 1'b1;
        else if (clr_req)    latch_q <= 1'b0;
    end

    // Visible value: latch, plus the line level for level-type bits.
    always_comb pend_o = latch_q | (~edge_mode & line);

    assign latch_o = latch_q;

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && line && !line_prev && !restore_we) |=> latch_q);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && clr_req && !restore_we) |=> latch_q);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req && !(edge_mode && rise) && !restore_we) |=> !latch_q);

    assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restore_we |=> (latch_q == $past(restore_bit)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req && !restore_we && !(edge_mode && line && !line_prev))
        |=> $stable(latch_q));
endmodule

// File: rtl/pend_bank.sv
// Module: pending state for 32 interrupts starting at BASE_ID. Bits outside
// the implemented range are tied to zero. Assumes BASE_ID is a multiple
// of 32 and that all inputs are synchronous to clk.
module pend_bank #(
    parameter int BASE_ID   = 0,
    parameter int NUM_IMPL  = 28,
    parameter int SGI_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] line_i,
    input  logic [31:0] trig_edge_i,
    input  logic        set_we_i,
    input  logic [31:0] set_mask_i,
    input  logic        clr_we_i,
    input  logic [31:0] clr_mask_i,
    input  logic [31:0] activate_i,
    input  logic        restore_we_i,
    input  logic [31:0] restore_val_i,
    output logic [31:0] pend_rd_o,
    output logic [31:0] latch_o,
    output logic [31:0] level_snap_o
);
    import pend_pkg::*;

    localparam logic [BANK_W-1:0] VALID = impl_mask(BASE_ID, NUM_IMPL, SGI_LIMIT);

    logic [BANK_W-1:0] line_q, rise;
    logic [BANK_W-1:0] set_req, clr_req;

    initial begin
        if (BASE_ID % BANK_W != 0) $error("BASE_ID must be a multiple of 32");
    end

    pend_edge_det #(.W(BANK_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .line_q_o (line_q),
        .rise_o   (rise)
    );

    // Expand write strobes into per-bit set and clear requests.
    always_comb begin
        set_req = set_mask_i & {BANK_W{set_we_i}};
        clr_req = (clr_mask_i & {BANK_W{clr_we_i}}) | activate_i;
    end

    // Level snapshot, limited to implemented bits.
    always_comb level_snap_o = line_i & VALID;

    for (genvar n = 0; n < BANK_W; n++) begin : g_bit
        if (VALID[n]) begin : g_impl
            pend_cell u_cell (
                .clk         (clk),
                .rst_n       (rst_n),
                .edge_mode   (trig_edge_i[n]),
                .line        (line_i[n]),
                .line_prev   (line_q[n]),
                .rise        (rise[n]),
                .set_req     (set_req[n]),
                .clr_req     (clr_req[n]),
                .restore_we  (restore_we_i),
                .restore_bit (restore_val_i[n]),
                .latch_o     (latch_o[n]),
                .pend_o      (pend_rd_o[n])
            );
        end else begin : g_absent
            assign latch_o[n]   = 1'b0;
            assign pend_rd_o[n] = 1'b0;
        end
    end

    assert_edge_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_rd_o ^ latch_o) & trig_edge_i) == '0);

    assert_latch_in_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o & ~pend_rd_o) == '0);
endmodule

// File: tb/tb_pend_bank.sv
module tb_pend_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] line_i, trig_edge_i, set_mask_i, clr_mask_i, activate_i, restore_val_i;
    logic        set_we_i, clr_we_i, restore_we_i;
    logic [31:0] pend_rd_o, latch_o, level_snap_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pend_bank dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .trig_edge_i(trig_edge_i),
        .set_we_i(set_we_i), .set_mask_i(set_mask_i), .clr_we_i(clr_we_i),
        .clr_mask_i(clr_mask_i), .activate_i(activate_i), .restore_we_i(restore_we_i),
        .restore_val_i(restore_val_i), .pend_rd_o(pend_rd_o), .latch_o(latch_o),
        .level_snap_o(level_snap_o)
    );

    // Bit 16 is edge type, bit 17 is level type; implemented bits are 16..27.
    localparam logic [31:0] B16  = 32'h0001_0000;
    localparam logic [31:0] B17  = 32'h0002_0000;
    localparam logic [31:0] IMPL = 32'h0FFF_0000;

    typedef struct packed {
        logic [31:0] line;
        logic [31:0] setm;
        logic [31:0] clrm;
        logic [31:0] act;
        logic [31:0] exp_latch;
        logic [31:0] exp_pend;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},                       // idle
        '{B16,   32'h0, 32'h0, 32'h0, B16,   B16},                         // R2 rise
        '{32'h0, 32'h0, 32'h0, 32'h0, B16,   B16},                         // R2 hold
        '{32'h0, 32'h0, B16,   32'h0, 32'h0, 32'h0},                       // R3 clear write
        '{32'h0, B16,   32'h0, 32'h0, B16,   B16},                         // set write
        '{32'h0, 32'h0, 32'h0, B16,   32'h0, 32'h0},                       // R3 activation
        '{B17,   32'h0, 32'h0, 32'h0, 32'h0, B17},                         // R4 level high
        '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},                       // R4 level low
        '{32'h0, B17,   32'h0, 32'h0, B17,   B17},                         // R5 set
        '{B17,   32'h0, 32'h0, 32'h0, B17,   B17},                         // R5
        '{B17,   32'h0, B17,   32'h0, 32'h0, B17},                         // R6 clear, line high
        '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},                       // R4 drop
        '{B17,   B17,   32'h0, 32'h0, B17,   B17},                         // R5
        '{B17,   32'h0, 32'h0, B17,   32'h0, B17},                         // R6 activation
        '{32'h0, B16|B17, B16|B17, 32'h0, B16|B17, B16|B17},               // R7
        '{32'h0, 32'h0, 32'h0, B16|B17, 32'h0, 32'h0},                     // R3
        '{32'h0, B16,   32'h0, B16,   B16,   B16},                         // R7 act
        '{32'h0, 32'h0, B16,   32'h0, 32'h0, 32'h0},                       // R3
        '{32'h4000_0020, 32'hC000_0021, 32'h0, 32'h0, 32'h0, 32'h0},       // R10
        '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0}                        // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        set_we_i = 0; clr_we_i = 0; restore_we_i = 0;
        set_mask_i = 0; clr_mask_i = 0; activate_i = 0; restore_val_i = 0;
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; line_i = 0; trig_edge_i = 32'h4001_0020; idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        check("R1 latch", latch_o, 32'h0);
        check("R1 pend", pend_rd_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            line_i     = TBL[i].line;
            set_we_i   = |TBL[i].setm; set_mask_i = TBL[i].setm;
            clr_we_i   = |TBL[i].clrm; clr_mask_i = TBL[i].clrm;
            activate_i = TBL[i].act;
            @(posedge clk); #2;
            check($sformatf("R2-table step %0d latch", i), latch_o, TBL[i].exp_latch);
            check($sformatf("R4-table step %0d pend", i), pend_rd_o, TBL[i].exp_pend);
        end

        // R9: level snapshot follows implemented lines
        @(negedge clk); idle_inputs(); trig_edge_i = 32'h0; line_i = 32'hFFFF_FFFF;
        #1 check("R9 snapshot all", level_snap_o, IMPL);
        check("R10 pend level invalid", pend_rd_o, IMPL);
        line_i = 32'h0010_0000;
        #1 check("R9 snapshot one", level_snap_o, 32'h0010_0000);

        // R8: restore, overriding a clear in the same cycle
        @(negedge clk); line_i = 0; trig_edge_i = 32'hFFFF_FFFF;
        restore_we_i = 1; restore_val_i = 32'hFFFF_FFFF;
        clr_we_i = 1; clr_mask_i = 32'hFFFF_FFFF;
        #1 check("R8 before edge", latch_o, 32'h0);
        @(posedge clk); #2;
        check("R8 restore latch", latch_o, IMPL);
        check("R8 edge pend equals latch", pend_rd_o, latch_o);
        @(negedge clk); idle_inputs();
        restore_we_i = 1; restore_val_i = 32'h0000_5A5A;
        set_we_i = 1; set_mask_i = 32'h00F0_0000;
        @(posedge clk); #2;
        check("R8 restore beats set", latch_o, 32'h0000_5A5A & IMPL);

        // R1: reset clears a set latch
        @(negedge clk); idle_inputs(); set_we_i = 1; set_mask_i = IMPL;
        @(negedge clk); idle_inputs(); rst_n = 0;
        @(posedge clk); #2;
        check("R1 reset latch", latch_o, 32'h0);
        check("R1 reset pend", pend_rd_o, 32'h0);
        @(negedge clk); rst_n = 1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule